// File: doc/BRIEF.md
# Write Protect Command Sequence Detector

This block sits between the bus write capture logic and the page programming controller of a byte-wide nonvolatile storage array. It watches each captured write (address, data and a one-cycle strobe) and decides whether that write may reach the array. It holds a protection state. While protection is off, ordinary writes pass straight through. While protection is on, a write reaches the array only when a three-write unlock prefix comes before it. That prefix opens one page-load window, and the window closes again when the page's program cycle ends.

A six-write command sequence turns protection off. The change takes effect a fixed number of cycles later, which stands in for the program-cycle time. The command writes are consumed by the block and are never forwarded. When a sequence is broken partway, the matcher returns to idle and the breaking write is handled as an ordinary write. Any write captured while the program cycle is busy is dropped entirely. Keeping the mode across power loss is not part of this block: the mode is a register with a reset value.

Top module: `writeGuard`

## Requirements
- R1: After reset, protMode is 0 (open mode), and allowWr and illegalWr are 0.
- R2: Each verdict is a one-cycle pulse in the cycle after the strobe. In open mode, a write that is not part of a command sequence raises allowWr and leaves illegalWr low.
- R3: Command addresses are compared on the low ADDR_W-2 address bits only, so the top two address bits may hold any value. The two command addresses are 5555h and 2AAAh.
- R4: The unlock sequence is data AAh at 5555h, then 55h at 2AAAh, then A0h at 5555h. It sets protMode to 1 in the cycle after its third write, whatever the previous mode was. None of its writes raises allowWr or illegalWr.
- R5: After an unlock, every non-busy write raises allowWr. This continues until busy has been seen high and then low. From that point the block is protected again.
- R6: While protected and with no window open, a write that does not advance a command sequence raises illegalWr and never raises allowWr.
- R7: A write that fails to match the next expected step of a partly matched sequence returns the matcher to idle. That write is handled as an ordinary write: allowWr in open mode, illegalWr when protected.
- R8: The disable sequence is AAh at 5555h, 55h at 2AAAh, 80h at 5555h, AAh at 5555h, 55h at 2AAAh, 20h at 5555h. protMode stays 1 through the following WC_CYCLES-1 cycles and falls WC_CYCLES cycles after the sixth strobe. None of these writes is forwarded.
- R9: A strobe while busy is high raises neither allowWr nor illegalWr and does not change the matcher's progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStrobe | input | 1 | One-cycle pulse marking a captured bus write |
| wrAddr | input | ADDR_W | Captured write address |
| wrData | input | 8 | Captured write data |
| busy | input | 1 | High while the array program cycle runs |
| allowWr | output | 1 | Pulse: the last captured write is forwarded to the page controller |
| protMode | output | 1 | 1 while write protection is on |
| illegalWr | output | 1 | Pulse: the last captured write was refused under protection |

## Verification
Several properties are checked on every cycle. The two verdicts never coincide. A busy-time strobe yields no verdict and leaves the matcher where it was. A refused write always follows a protected state. Protection rises only on an unlock and falls only when the disable timer expires. A window is never open while protection is off. What only the directed scenarios can show is the content of the command sequences: the exact address and data pairs, the fact that the top address bits are ignored, the way a broken or busy-interrupted sequence behaves, the exact cycle at which a disable takes hold, and the point at which the page window closes once busy falls.

// File: rtl/wgPkg.sv
package wgPkg;

  localparam int DATA_W  = 8;
  localparam int SEQ_LEN = 6;

  // strobes from the matcher to the state keeper
  typedef struct packed {
    logic passWr;
    logic badWr;
    logic armUnlock;
    logic startDisarm;
  } wgCtl_t;

  localparam logic [15:0]       ADDR_A      = 16'h5555;
  localparam logic [15:0]       ADDR_B      = 16'h2AAA;
  localparam logic [DATA_W-1:0] UNLOCK_DATA = 8'hA0;

  // disable sequence, step by step
  function automatic logic [15:0] seqAddr(input int idx);
    case (idx)
      1, 4:    seqAddr = ADDR_B;
      default: seqAddr = ADDR_A;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] seqData(input int idx);
    case (idx)
      0, 3:    seqData = 8'hAA;
      1, 4:    seqData = 8'h55;
      2:       seqData = 8'h80;
      default: seqData = 8'h20;
    endcase
  endfunction

endpackage

// File: rtl/wgMatch.sv
module wgMatch
  import wgPkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              busy,
  input  logic              winOpen,
  input  logic              protMode,
  output wgCtl_t            ctl
);

  localparam int CMP_W   = ADDR_W - 2;
  localparam int STEP_W  = $clog2(SEQ_LEN);
  localparam logic [STEP_W-1:0] LAST_STEP   = STEP_W'(SEQ_LEN - 1);
  localparam logic [STEP_W-1:0] BRANCH_STEP = STEP_W'(2);
  localparam logic [15:0] UNLOCK_ADDR = ADDR_A;

  logic [CMP_W-1:0]   addrLo;
  logic [SEQ_LEN-1:0] hitVec;
  logic               unlockHit;
  logic [STEP_W-1:0]  step, stepNext;
  logic               take;

  assign addrLo = wrAddr[CMP_W-1:0];
  assign take   = wrStrobe && !busy;

  generate
    for (genvar k = 0; k < SEQ_LEN; k++) begin : gHit
      localparam logic [15:0]       K_ADDR = seqAddr(k);
      localparam logic [DATA_W-1:0] K_DATA = seqData(k);
      assign hitVec[k] = (addrLo == K_ADDR[CMP_W-1:0]) && (wrData == K_DATA);
    end
  endgenerate

  assign unlockHit = (addrLo == UNLOCK_ADDR[CMP_W-1:0]) && (wrData == UNLOCK_DATA);

  always_comb begin
    ctl      = '0;
    stepNext = step;
    if (take) begin
      if (winOpen) begin
        ctl.passWr = 1'b1;
      end else if (step == BRANCH_STEP && unlockHit) begin
        ctl.armUnlock = 1'b1;
        stepNext      = '0;
      end else if (hitVec[step]) begin
        if (step == LAST_STEP) begin
          ctl.startDisarm = 1'b1;
          stepNext        = '0;
        end else begin
          stepNext = STEP_W'(step + 1'b1);
        end
      end else begin
        stepNext   = '0;
        ctl.passWr = !protMode;
        ctl.badWr  = protMode;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) step <= '0;
    else       step <= stepNext;
  end

  // R9: a write seen while busy leaves sequence progress alone
  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && busy) |=> $stable(step));

  // R7: a refused or forwarded write leaves the matcher idle
  a_r7_verdict_idles: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.badWr || (ctl.passWr && !winOpen)) |=> (step == '0));

endmodule

// File: rtl/wgState.sv
module wgState
  import wgPkg::*;
#(
  parameter int   WC_CYCLES  = 8,
  parameter logic PROT_RESET = 1'b0
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   busy,
  input  wgCtl_t ctl,
  output logic   protMode,
  output logic   winOpen,
  output logic   allowWr,
  output logic   illegalWr
);

  localparam int CNT_W = $clog2(WC_CYCLES + 1);

  logic             busyQ;
  logic             pend;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protMode  <= PROT_RESET;
      winOpen   <= 1'b0;
      busyQ     <= 1'b0;
      pend      <= 1'b0;
      cnt       <= '0;
      allowWr   <= 1'b0;
      illegalWr <= 1'b0;
    end else begin
      busyQ     <= busy;
      allowWr   <= ctl.passWr;
      illegalWr <= ctl.badWr;
      if (ctl.armUnlock) begin
        protMode <= 1'b1;
        winOpen  <= 1'b1;
        pend     <= 1'b0;
      end else begin
        if (winOpen && busyQ && !busy) winOpen <= 1'b0;
        if (ctl.startDisarm) begin
          pend <= 1'b1;
          cnt  <= CNT_W'(WC_CYCLES - 1);
        end else if (pend) begin
          if (cnt == '0) begin
            pend     <= 1'b0;
            protMode <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      end
    end
  end

  // R5: a page window exists only under protection
  a_r5_window_protected: assert property (@(posedge clk) disable iff (!rstN)
    winOpen |-> protMode);

  // R4: protection rises only on an accepted unlock
  a_r4_rise_on_unlock: assert property (@(posedge clk) disable iff (!rstN)
    $rose(protMode) |-> $past(ctl.armUnlock));

  // R8: protection falls only when the disable delay runs out
  a_r8_fall_after_delay: assert property (@(posedge clk) disable iff (!rstN)
    $fell(protMode) |-> $past(pend));

endmodule

// File: rtl/writeGuard.sv
module writeGuard
  import wgPkg::*;
#(
  parameter int   ADDR_W     = 17,
  parameter int   WC_CYCLES  = 8,
  parameter logic PROT_RESET = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              busy,
  output logic              allowWr,
  output logic              protMode,
  output logic              illegalWr
);

  wgCtl_t ctl;
  logic   winOpen;

  wgMatch #(.ADDR_W(ADDR_W)) u_match (
    .clk      (clk),
    .rstN     (rstN),
    .wrStrobe (wrStrobe),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .busy     (busy),
    .winOpen  (winOpen),
    .protMode (protMode),
    .ctl      (ctl)
  );

  wgState #(.WC_CYCLES(WC_CYCLES), .PROT_RESET(PROT_RESET)) u_state (
    .clk       (clk),
    .rstN      (rstN),
    .busy      (busy),
    .ctl       (ctl),
    .protMode  (protMode),
    .winOpen   (winOpen),
    .allowWr   (allowWr),
    .illegalWr (illegalWr)
  );

  // R2: a write gets at most one verdict
  a_r2_one_verdict: assert property (@(posedge clk) disable iff (!rstN)
    !(allowWr && illegalWr));

  // R9: a busy-time strobe yields no verdict
  a_r9_busy_silent: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && busy) |=> (!allowWr && !illegalWr));

  // R6: a refusal only follows a protected state
  a_r6_refuse_needs_prot: assert property (@(posedge clk) disable iff (!rstN)
    illegalWr |-> $past(protMode));

endmodule

// File: tb/writeGuard_tb.sv
module writeGuard_tb;

  localparam int ADDR_W = 17;
  localparam int WC     = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrStrobe = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [7:0]        wrData = '0;
  logic              busy = 1'b0;
  logic              allowWr, protMode, illegalWr;

  int nChk = 0;
  int nBad = 0;
  logic gotA, gotI;

  always #10 clk = ~clk;

  writeGuard #(.ADDR_W(ADDR_W), .WC_CYCLES(WC)) u_dut (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrAddr(wrAddr),
    .wrData(wrData), .busy(busy), .allowWr(allowWr),
    .protMode(protMode), .illegalWr(illegalWr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one captured write; verdict sampled half a cycle after the edge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    wrAddr = a; wrData = d; wrStrobe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrStrobe = 1'b0;
    gotA = allowWr; gotI = illegalWr;
  endtask

  task automatic wrExpect(input string tag, input logic [ADDR_W-1:0] a,
                          input logic [7:0] d, input logic ea, input logic ei);
    wr(a, d);
    chk({tag, " allow"}, {31'd0, gotA}, {31'd0, ea});
    chk({tag, " illegal"}, {31'd0, gotI}, {31'd0, ei});
  endtask

  task automatic busyPulseWithWrite(input string tag);
    busy = 1'b1;
    @(negedge clk);
    wrExpect(tag, 17'h00300, 8'h77, 1'b0, 1'b0);
    busy = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 protMode", {31'd0, protMode}, 32'd0);
    chk("R1 allowWr", {31'd0, allowWr}, 32'd0);
    chk("R1 illegalWr", {31'd0, illegalWr}, 32'd0);
  endtask

  task automatic t_open_write;
    wrExpect("R2 open write", 17'h01234, 8'h33, 1'b1, 1'b0);
    @(negedge clk);
    chk("R2 pulse ends", {31'd0, allowWr}, 32'd0);
  endtask

  task automatic t_open_break;
    wrExpect("R7 open first step", 17'h05555, 8'hAA, 1'b0, 1'b0);
    wrExpect("R7 open breaker", 17'h01234, 8'h33, 1'b1, 1'b0);
  endtask

  task automatic t_unlock_high_bits;
    wrExpect("R3 R4 step1", 17'h1D555, 8'hAA, 1'b0, 1'b0);
    wrExpect("R3 R4 step2", 17'h0AAAA, 8'h55, 1'b0, 1'b0);
    wrExpect("R3 R4 step3", 17'h15555, 8'hA0, 1'b0, 1'b0);
    chk("R4 protMode set", {31'd0, protMode}, 32'd1);
    wrExpect("R5 window byte0", 17'h00200, 8'h11, 1'b1, 1'b0);
    wrExpect("R5 window byte1", 17'h00201, 8'h12, 1'b1, 1'b0);
    busyPulseWithWrite("R9 busy in window");
    wrExpect("R5 R6 after window", 17'h00202, 8'h13, 1'b0, 1'b1);
  endtask

  task automatic t_prot_break;
    wrExpect("R7 prot first step", 17'h05555, 8'hAA, 1'b0, 1'b0);
    wrExpect("R7 prot breaker", 17'h00100, 8'h12, 1'b0, 1'b1);
    wrExpect("R7 prot orphan 2", 17'h02AAA, 8'h55, 1'b0, 1'b1);
    wrExpect("R7 prot orphan 3", 17'h05555, 8'hA0, 1'b0, 1'b1);
    chk("R7 still protected", {31'd0, protMode}, 32'd1);
  endtask

  task automatic t_busy_mid_seq;
    wrExpect("R9 seq step1", 17'h05555, 8'hAA, 1'b0, 1'b0);
    busy = 1'b1;
    wrExpect("R9 busy junk", 17'h05555, 8'h5A, 1'b0, 1'b0);
    busy = 1'b0;
    @(negedge clk);
    wrExpect("R9 seq step2", 17'h02AAA, 8'h55, 1'b0, 1'b0);
    wrExpect("R9 seq step3", 17'h05555, 8'hA0, 1'b0, 1'b0);
    wrExpect("R9 R5 window open", 17'h00400, 8'h44, 1'b1, 1'b0);
    busyPulseWithWrite("R9 busy closes");
    wrExpect("R5 closed again", 17'h00401, 8'h45, 1'b0, 1'b1);
  endtask

  task automatic t_disable;
    wrExpect("R8 d1", 17'h05555, 8'hAA, 1'b0, 1'b0);
    wrExpect("R8 d2", 17'h02AAA, 8'h55, 1'b0, 1'b0);
    wrExpect("R8 d3", 17'h05555, 8'h80, 1'b0, 1'b0);
    wrExpect("R8 d4", 17'h05555, 8'hAA, 1'b0, 1'b0);
    wrExpect("R8 d5", 17'h02AAA, 8'h55, 1'b0, 1'b0);
    wrExpect("R8 d6", 17'h05555, 8'h20, 1'b0, 1'b0);
    repeat (WC - 1) @(posedge clk);
    @(negedge clk);
    chk("R8 still protected", {31'd0, protMode}, 32'd1);
    @(negedge clk);
    chk("R8 open after delay", {31'd0, protMode}, 32'd0);
    wrExpect("R8 R2 write after disable", 17'h00500, 8'h66, 1'b1, 1'b0);
  endtask

  initial begin
    #(20 * 100000);
    nBad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_open_write();
    t_open_break();
    t_unlock_high_bits();
    t_prot_break();
    t_busy_mid_seq();
    t_disable();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

endmodule